// File: doc/BRIEF.md
# Per-Slave Bus Arbiter

This block decides which of N bus masters may drive one slave port of a multi-layer interconnect. Every slave port gets its own copy, with its own configuration, so neighbouring slaves can run different strategies. Each master presents a request, a first-beat flag, a last-beat flag and an accept bit that tells it the slave took its current beat. The arbiter returns a one-hot grant vector and the binary index of the winner. Software picks fixed priority or round robin. In round-robin mode it also picks what happens when nobody is asking: the slave goes ungranted, stays with the master that used it last, or is parked on a programmed master.

The arbiter is a four-state machine. In `S_IDLE` no grant is driven. In `S_PARK` a default master holds the grant with no request behind it. In `S_HOLD` a requester owns the slave between bursts. In `S_BURST` the owner is inside an open burst. Arbitration runs in every cycle in `S_IDLE` and `S_PARK`. In `S_HOLD` and `S_BURST` it runs only on an arbitration point: the owner drops its request, the owner has a beat accepted that closes its tenure, or the slot counter runs out.

The transitions are:
- A winner is found: `*`→`S_HOLD`.
- An accepted beat opens a burst: `S_HOLD`→`S_BURST`.
- Nobody requests and a default master applies: `*`→`S_PARK`.
- Nobody requests and no default master applies: `*`→`S_IDLE`.
- Otherwise the state stays where it is.

A new grant appears on the outputs one clock after the arbitration point that chose it.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While reset is asserted, and after its release until the first clock edge, `gnt` is all zeros and `gnt_idx` is 0.
- R2: `gnt` is one-hot or zero. When it is non-zero, `gnt_idx` is the position of its set bit. When it is zero, `gnt_idx` is 0.
- R3: When an arbitration point finds at least one request, the next clock's grant goes to one of the masters that were requesting.
- R4: With `cfg_rr_mode`=0 (fixed priority), master i has the 2-bit priority `cfg_prio[2i+1:2i]`. The highest value wins, and ties go to the lowest index.
- R5: With `cfg_rr_mode`=1 (round robin), the search begins at the index after the last master granted on a request (0 after reset). It wraps from N-1 to 0 and grants the first requester found.
- R6: With no request at an arbitration point, the slave goes ungranted if `cfg_rr_mode`=0 or if `cfg_dflt_pol` is 0 ("none") or 3.
- R7: With `cfg_rr_mode`=1 and `cfg_dflt_pol`=1 ("last"), an idle slave stays parked on the last master granted on a request. If no master has been granted since reset, the slave is ungranted.
- R8: With `cfg_rr_mode`=1, `cfg_dflt_pol`=2 ("fixed") and `cfg_dflt_idx` < N, an idle slave is parked on `cfg_dflt_idx`. A request from another master moves the grant to it on the next clock, with no ungranted cycle in between.
- R9: While the owner keeps requesting and its accept bit is low, the grant does not change, whatever other masters do.
- R10: An accepted beat with first=1 and last=0 opens a burst. The owner keeps the grant until it has a beat accepted with last=1.
- R11: A non-zero `cfg_slot_lim` L is loaded at each grant. The L-th accepted beat of the tenure is an arbitration point, even in the middle of a burst. L=0 never breaks a burst.
- R12: An accepted beat outside an open burst that does not open one is an arbitration point, so round robin passes the slave on to the next requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rr_mode | input | 1 | 1 = round robin, 0 = fixed priority |
| cfg_dflt_pol | input | 2 | Idle policy: 0 none, 1 last, 2 fixed, 3 none |
| cfg_dflt_idx | input | IW | Master parked under the fixed policy |
| cfg_prio | input | N*2 | 2-bit priority per master, master i at bits [2i+1:2i] |
| cfg_slot_lim | input | SW | Accepted beats per tenure; 0 = unlimited |
| m_req | input | N | Per-master request |
| m_bst_first | input | N | Per-master: current beat opens a burst |
| m_bst_last | input | N | Per-master: current beat closes a burst |
| m_xfer_ok | input | N | Per-master: current beat accepted by the slave |
| gnt | output | N | One-hot grant |
| gnt_idx | output | IW | Index of granted master |

## Verification
The bench targets these corner cases:
- **Round-robin wrap.** A pointer that fails to wrap, or that restarts at 0, hands the second grant back to the same master.
- **Beats without an accept.** A design that re-arbitrates on such beats moves the grant in the middle of a burst.
- **The last accepted beat under a slot limit of 3.** An off-by-one counter breaks the burst one beat early or one beat late, and a limit of 0 must never break it.
- **The three idle policies.** The bench checks parking on the programmed master and on the last user, and the absence of parking in fixed-priority mode and before any grant since reset. A parked design that inserted an idle cycle before serving a new requester would show a zero grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PARK  = 2'd1,
        S_HOLD  = 2'd2,
        S_BURST = 2'd3
    } arb_state_e;

    typedef enum logic [1:0] {
        DP_NONE  = 2'd0,
        DP_LAST  = 2'd1,
        DP_FIXED = 2'd2,
        DP_RSVD  = 2'd3
    } dflt_pol_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N  = 11,
    parameter int PW = 2,
    parameter int IW = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic [IW-1:0]   win_idx
);
    // highest priority wins; strict compare keeps the lowest index on ties
    always_comb begin
        logic [PW-1:0] best;
        logic          found;
        best    = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i*PW +: PW] > best)) begin
                best    = prio[i*PW +: PW];
                found   = 1'b1;
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 11,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic [IW-1:0] win_idx
);
    // search begins one past the last winner and wraps modulo N
    always_comb begin
        logic found;
        int   c;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N; k++) begin
            c = int'(last_idx) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found   = 1'b1;
                win_idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] lim,
    input  logic          load,
    input  logic          beat,
    output logic          expire
);
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= lim;
        else if (beat && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // last permitted beat of the tenure is being accepted now
    assign expire = (lim != '0) && beat && (cnt_q == SW'(1));
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
    import arb_pkg::*;
#(
    parameter int N  = 11,
    parameter int PW = 2,
    parameter int SW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_rr_mode,
    input  logic [1:0]      cfg_dflt_pol,
    input  logic [IW-1:0]   cfg_dflt_idx,
    input  logic [N*PW-1:0] cfg_prio,
    input  logic [SW-1:0]   cfg_slot_lim,
    input  logic [N-1:0]    m_req,
    input  logic [N-1:0]    m_bst_first,
    input  logic [N-1:0]    m_bst_last,
    input  logic [N-1:0]    m_xfer_ok,
    output logic [N-1:0]    gnt,
    output logic [IW-1:0]   gnt_idx
);

    arb_state_e    st_q, st_d;
    logic [IW-1:0] own_q, own_d;
    logic [IW-1:0] last_q, last_d;
    logic          have_last_q, have_last_d;

    logic [IW-1:0] pr_win, rr_win, win;
    logic          any_req, own_req, acc, own_first, own_last;
    logic          opens, rearb, slot_expire, dflt_ok;
    dflt_pol_e     pol;

    // ---------------- candidate pickers ----------------
    arb_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_prio (
        .req     (m_req),
        .prio    (cfg_prio),
        .win_idx (pr_win)
    );

    arb_rr_pick #(.N(N), .IW(IW)) u_rr (
        .req      (m_req),
        .last_idx (last_q),
        .win_idx  (rr_win)
    );

    assign win     = cfg_rr_mode ? rr_win : pr_win;
    assign any_req = |m_req;

    // ---------------- owner beat decode ----------------
    assign own_req   = m_req[own_q];
    assign own_first = m_bst_first[own_q];
    assign own_last  = m_bst_last[own_q];
    assign acc       = ((st_q == S_HOLD) || (st_q == S_BURST)) && own_req && m_xfer_ok[own_q];
    assign opens     = acc && own_first && !own_last;
    assign pol       = dflt_pol_e'(cfg_dflt_pol);
    assign dflt_ok   = int'(cfg_dflt_idx) < N;

    // ---------------- slot limit ----------------
    arb_slot_timer #(.SW(SW)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .lim    (cfg_slot_lim),
        .load   (rearb),
        .beat   (acc),
        .expire (slot_expire)
    );

    // ---------------- arbitration point ----------------
    always_comb begin
        unique case (st_q)
            S_IDLE, S_PARK: rearb = 1'b1;
            S_HOLD:         rearb = !own_req || (acc && (!opens || slot_expire));
            S_BURST:        rearb = !own_req || (acc && (own_last || slot_expire));
            default:        rearb = 1'b1;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d        = st_q;
        own_d       = own_q;
        last_d      = last_q;
        have_last_d = have_last_q;
        if (rearb) begin
            if (any_req) begin
                st_d        = S_HOLD;
                own_d       = win;
                last_d      = win;
                have_last_d = 1'b1;
            end else if (cfg_rr_mode && pol == DP_LAST && have_last_q) begin
                st_d  = S_PARK;
                own_d = last_q;
            end else if (cfg_rr_mode && pol == DP_FIXED && dflt_ok) begin
                st_d  = S_PARK;
                own_d = cfg_dflt_idx;
            end else begin
                st_d  = S_IDLE;
                own_d = '0;
            end
        end else if (st_q == S_HOLD && opens) begin
            st_d = S_BURST;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            own_q       <= '0;
            last_q      <= '0;
            have_last_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            own_q       <= own_d;
            last_q      <= last_d;
            have_last_q <= have_last_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        if (st_q != S_IDLE) begin
            gnt[own_q] = 1'b1;
            gnt_idx    = own_q;
        end
    end

    // ---------------- assertions ----------------
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r3_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb && any_req) |=> ((gnt & $past(m_req)) != '0));

    a_r6_no_park_in_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rr_mode && rearb && !any_req) |=> (gnt == '0));

    a_r8_park_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PARK) |-> ($past(m_req) == '0));

    a_r9_hold_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BURST && own_req && !m_xfer_ok[own_q]) |=> ($stable(gnt_idx) && gnt != '0));

    a_r11_expire_is_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        slot_expire |-> rearb);

endmodule

// File: tb/sim_bus_slot_arbiter.sv
`timescale 1ns/1ps
module sim_bus_slot_arbiter;
    localparam int N  = 11;
    localparam int IW = 4;
    localparam int SW = 8;
    localparam int NV = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_rr_mode;
    logic [1:0]      cfg_dflt_pol;
    logic [IW-1:0]   cfg_dflt_idx;
    logic [N*2-1:0]  cfg_prio;
    logic [SW-1:0]   cfg_slot_lim;
    logic [N-1:0]    m_req, m_bst_first, m_bst_last, m_xfer_ok;
    logic [N-1:0]    gnt;
    logic [IW-1:0]   gnt_idx;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_slot_arbiter #(.N(N), .PW(2), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rr_mode(cfg_rr_mode), .cfg_dflt_pol(cfg_dflt_pol),
        .cfg_dflt_idx(cfg_dflt_idx), .cfg_prio(cfg_prio), .cfg_slot_lim(cfg_slot_lim),
        .m_req(m_req), .m_bst_first(m_bst_first), .m_bst_last(m_bst_last),
        .m_xfer_ok(m_xfer_ok), .gnt(gnt), .gnt_idx(gnt_idx)
    );

    // round robin, no default master, no slot limit
    localparam logic [N-1:0] T_REQ [NV] = '{11'h000, 11'h028, 11'h028, 11'h028, 11'h028,
                                            11'h028, 11'h028, 11'h028, 11'h001, 11'h000};
    localparam logic [N-1:0] T_FST [NV] = '{11'h000, 11'h000, 11'h000, 11'h000, 11'h000,
                                            11'h008, 11'h000, 11'h000, 11'h000, 11'h000};
    localparam logic [N-1:0] T_LST [NV] = '{11'h000, 11'h000, 11'h000, 11'h000, 11'h000,
                                            11'h000, 11'h000, 11'h008, 11'h000, 11'h000};
    localparam logic [N-1:0] T_OK  [NV] = '{11'h000, 11'h000, 11'h008, 11'h020, 11'h000,
                                            11'h008, 11'h008, 11'h008, 11'h000, 11'h000};
    localparam bit           T_VLD [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                            1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int           T_IDX [NV] = '{0, 3, 5, 3, 3, 3, 3, 5, 0, 0};
    localparam string        T_TAG [NV] = '{"R6", "R5", "R12", "R5", "R9",
                                            "R10", "R10", "R10", "R5", "R6"};

    task automatic check(input string rq, input bit ev, input int ei);
        logic [N-1:0]  eg;
        logic [IW-1:0] ex;
        eg = ev ? (N'(1) << ei) : '0;
        ex = ev ? IW'(ei) : '0;
        n_cmp++;
        if (gnt !== eg || gnt_idx !== ex) begin
            n_bad++;
            $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", rq, gnt, gnt_idx, eg, ex);
        end
    endtask

    task automatic drive(input logic [N-1:0] rq, input logic [N-1:0] fs,
                         input logic [N-1:0] ls, input logic [N-1:0] ok);
        m_req = rq; m_bst_first = fs; m_bst_last = ls; m_xfer_ok = ok;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic restart(input logic rr, input logic [1:0] pol, input int didx,
                           input logic [SW-1:0] lim);
        rst_n = 1'b0;
        cfg_rr_mode = rr; cfg_dflt_pol = pol; cfg_dflt_idx = IW'(didx); cfg_slot_lim = lim;
        drive('0, '0, '0, '0);
        step();
        step();
        check("R1 in reset", 1'b0, 0);
        rst_n = 1'b1;
        #1;
        check("R1 after release", 1'b0, 0);
    endtask

    function automatic logic [N-1:0] b(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        cfg_prio = '0;
        cfg_prio[2*2 +: 2] = 2'd3;
        cfg_prio[7*2 +: 2] = 2'd3;
        cfg_prio[9*2 +: 2] = 2'd1;

        // ---- vector table: round robin ----
        restart(1'b1, 2'd0, 0, '0);
        for (int v = 0; v < NV; v++) begin
            drive(T_REQ[v], T_FST[v], T_LST[v], T_OK[v]);
            step();
            check(T_TAG[v], T_VLD[v], T_IDX[v]);
        end

        // ---- R4 fixed priority, R6 no parking in that mode ----
        restart(1'b0, 2'd2, 6, '0);
        drive(b(2) | b(7) | b(9), '0, '0, '0); step(); check("R4 tie lowest index", 1'b1, 2);
        drive(b(2) | b(7) | b(9), '0, '0, b(2)); step(); check("R4 top prio keeps", 1'b1, 2);
        drive(b(7) | b(9), '0, '0, '0); step(); check("R4 next top", 1'b1, 7);
        drive(b(0) | b(9), '0, '0, '0); step(); check("R4 prio 1 over 0", 1'b1, 9);
        drive('0, '0, '0, '0); step(); check("R6 prio mode idle", 1'b0, 0);
        step(); check("R6 prio mode stays idle", 1'b0, 0);

        // ---- R8 fixed default master ----
        restart(1'b1, 2'd2, 6, '0);
        step(); check("R8 park default", 1'b1, 6);
        drive(b(4), '0, '0, '0); step(); check("R8 no idle gap", 1'b1, 4);
        drive(b(4), '0, '0, b(4)); step(); check("R12 lone requester regranted", 1'b1, 4);
        drive('0, '0, '0, '0); step(); check("R8 back to default", 1'b1, 6);

        // ---- R7 last-accessed default ----
        restart(1'b1, 2'd1, 0, '0);
        step(); check("R7 no history no park", 1'b0, 0);
        drive(b(9), '0, '0, '0); step(); check("R7 grant 9", 1'b1, 9);
        drive('0, '0, '0, '0); step(); check("R7 park last", 1'b1, 9);
        drive(b(2), '0, '0, '0); step(); check("R7 park to requester", 1'b1, 2);
        drive('0, '0, '0, '0); step(); check("R7 park new last", 1'b1, 2);

        // ---- R6 reserved policy code acts as none ----
        restart(1'b1, 2'd3, 0, '0);
        drive(b(1), '0, '0, '0); step(); check("R6 grant 1", 1'b1, 1);
        drive('0, '0, '0, '0); step(); check("R6 policy 3 no park", 1'b0, 0);

        // ---- R11 slot limit 3 breaks a burst ----
        restart(1'b1, 2'd0, 0, 8'd3);
        drive(b(1) | b(8), '0, '0, '0); step(); check("R11 grant 1", 1'b1, 1);
        drive(b(1) | b(8), b(1), '0, b(1)); step(); check("R11 beat 1", 1'b1, 1);
        drive(b(1) | b(8), '0, '0, b(1)); step(); check("R11 beat 2", 1'b1, 1);
        drive(b(1) | b(8), '0, '0, b(1)); step(); check("R11 beat 3 breaks", 1'b1, 8);

        // ---- R11 limit 0 never breaks ----
        restart(1'b1, 2'd0, 0, '0);
        drive(b(1) | b(8), '0, '0, '0); step();
        drive(b(1) | b(8), b(1), '0, b(1)); step();
        for (int i = 0; i < 6; i++) begin
            drive(b(1) | b(8), '0, '0, b(1)); step();
        end
        check("R11 limit 0 holds", 1'b1, 1);
        drive(b(1) | b(8), '0, '0, '0); step(); check("R9 no accept holds", 1'b1, 1);
        drive(b(1) | b(8), '0, b(1), b(1)); step(); check("R10 last ends burst", 1'b1, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule